// File: doc/BRIEF.md
# HDLC Frame Address Recognizer

This block decides, from the address field of a received HDLC frame, whether the frame is kept or dropped. It watches a byte stream that has already been stripped of flags and stuffing bits. The first byte of each frame comes with a start-of-frame strobe. Depending on a mode input, the block treats either one byte or two bytes at the head of the frame as the address field. It compares them with four programmable match registers, two for the high byte and two for the low byte. For the high byte it also checks two fixed broadcast values.

At the end of the address field the block latches three results:

- an accept flag;
- a 2-bit code naming the high-byte entry that matched, which also carries the command/response bit of the received high byte when the first high register matched;
- a 1-bit code naming the low-byte register that matched.

These results stay unchanged until the next frame starts. Downstream receive logic uses the accept flag to store or discard the rest of the frame. Software can read the codes to learn which station address the frame was sent to.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset, frameAccept, hiCode and loCode are all zero.
- R2: In two-byte mode, the high byte is compared with hiAddrA ignoring bit 1 (the C/R bit). On a match, hiCode is {1, bit 1 of the received high byte}: 2'b10 when C/R is 0 and 2'b11 when C/R is 1.
- R3: In two-byte mode, a high byte equal to hiAddrB in all eight bits, and not matching hiAddrA, gives hiCode 2'b00. A byte that differs from hiAddrB only in bit 1 does not match hiAddrB.
- R4: In two-byte mode, a high byte of 0xFE or 0xFC that matches neither register gives hiCode 2'b01. When hiAddrB equals the received byte, the result is hiAddrB (2'b00), not broadcast.
- R5: When hiAddrA and hiAddrB hold the same value, a high byte matching both gives hiCode 2'b10 or 2'b11.
- R6: The low address byte is compared with loAddrA and loAddrB in all eight bits. loCode is 1 for a loAddrA match and 0 otherwise. When both registers match, loAddrA is reported (1).
- R7: In one-byte mode (twoByteMode=0 at the start-of-frame byte), the first byte is the low address byte, and hiCode becomes 2'b00.
- R8: frameAccept becomes 1 only if every address byte of the selected mode matches some entry. That means high and low in two-byte mode, and low only in one-byte mode. A high byte that matches nothing, or a low byte that matches nothing, leaves frameAccept at 0.
- R9: The results appear on the outputs in the clock cycle after the last address byte is accepted. They hold while further bytes of the same frame arrive, until the next start-of-frame byte.
- R10: In two-byte mode, a start-of-frame byte clears all three outputs to zero from the next cycle until the low byte arrives. A start-of-frame byte received while the low byte is still awaited restarts the address field with the new byte as the first one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | byteData holds a received byte this cycle |
| sofStb | input | 1 | With byteValid, marks the first byte of a frame |
| byteData | input | 8 | Received byte |
| twoByteMode | input | 1 | 1 selects a two-byte address field, 0 a one-byte field; sampled on the start-of-frame byte |
| hiAddrA | input | 8 | First high-byte match register (C/R bit ignored) |
| hiAddrB | input | 8 | Second high-byte match register (exact compare) |
| loAddrA | input | 8 | First low-byte match register |
| loAddrB | input | 8 | Second low-byte match register |
| frameAccept | output | 1 | 1 keeps the frame, 0 discards it |
| hiCode | output | 2 | High-byte result: 00 second register, 01 broadcast, 1x first register with C/R in bit 0 |
| loCode | output | 1 | Low-byte result: 1 first register, 0 second register |

## Verification
High bytes are driven in several forms:

- the first register's value with the C/R bit set and with it clear;
- the second register's exact value;
- the second register's value with only the C/R bit flipped;
- both broadcast values;
- a value that matches nothing.

Together these separate the masked compare from the exact compare and show that the C/R bit reaches the code. Runs with both high registers loaded with the same value, and both low registers loaded with the same value, expose the priority order. One-byte frames show the first byte routed to the low compare. Trailing bytes, and a start-of-frame byte that arrives in the middle of an address field, show that results hold, clear and restart on the right cycles.

// File: rtl/hdlc_addr_filter_pkg.sv
package hdlc_addr_filter_pkg;

  typedef struct packed {
    logic startFrame;
    logic takeHi;
    logic takeLo;
    logic twoMode;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_LO = 2'd1,
    ST_DONE    = 2'd2
  } ctrlState_t;

  localparam logic [1:0] HI_CODE_REG_B = 2'b00;
  localparam logic [1:0] HI_CODE_BCAST = 2'b01;
  localparam logic [1:0] HI_CODE_NONE  = 2'b00;

endpackage

// File: rtl/addr_compare.sv
module addr_compare #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] IGNORE_MASK = '0
) (
  input  logic [WIDTH-1:0] rxByte,
  input  logic [WIDTH-1:0] refByte,
  output logic             hit
);

  localparam logic [WIDTH-1:0] CARE_MASK = ~IGNORE_MASK;

  logic [WIDTH-1:0] diffBits;

  always_comb begin
    diffBits = (rxByte ^ refByte) & CARE_MASK;
    hit      = (diffBits == '0);
  end

endmodule

// File: rtl/addr_filter_ctrl.sv
module addr_filter_ctrl
  import hdlc_addr_filter_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         byteValid,
  input  logic         sofStb,
  input  logic         twoByteMode,
  output ctrlStrobes_t strobes
);

  ctrlState_t state;
  ctrlState_t nextState;

  always_comb begin
    strobes   = '0;
    nextState = state;
    if (byteValid && sofStb) begin
      strobes.startFrame = 1'b1;
      if (twoByteMode) begin
        strobes.takeHi = 1'b1;
        nextState      = ST_WAIT_LO;
      end else begin
        strobes.takeLo  = 1'b1;
        strobes.twoMode = 1'b0;
        nextState       = ST_DONE;
      end
    end else if (byteValid && (state == ST_WAIT_LO)) begin
      strobes.takeLo  = 1'b1;
      strobes.twoMode = 1'b1;
      nextState       = ST_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= nextState;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.takeHi && strobes.takeLo)); // R10

  AST_IGNORE_AFTER_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && byteValid && !sofStb) |-> !strobes.takeLo && !strobes.takeHi); // R9

endmodule

// File: rtl/addr_filter_dp.sv
module addr_filter_dp
  import hdlc_addr_filter_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CR_BIT = 1,
  parameter logic [ADDR_W-1:0] BCAST_A = 8'hFE,
  parameter logic [ADDR_W-1:0] BCAST_B = 8'hFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] byteData,
  input  logic [ADDR_W-1:0] hiAddrA,
  input  logic [ADDR_W-1:0] hiAddrB,
  input  logic [ADDR_W-1:0] loAddrA,
  input  logic [ADDR_W-1:0] loAddrB,
  output logic              frameAccept,
  output logic [1:0]        hiCode,
  output logic              loCode
);

  localparam logic [ADDR_W-1:0] CR_MASK  = ADDR_W'(1) << CR_BIT;
  localparam int                N_BCAST  = 2;
  localparam int                N_LO_REG = 2;

  logic                hiAHit;
  logic                hiBHit;
  logic [N_BCAST-1:0]  bcastHit;
  logic [N_LO_REG-1:0] loHit;
  logic [ADDR_W-1:0]   loRef [N_LO_REG];

  logic [1:0] hiCodeNow;
  logic       hiHitNow;
  logic       loCodeNow;
  logic       loHitNow;

  logic [1:0] hiPendCode;
  logic       hiPendHit;

  addr_compare #(.WIDTH(ADDR_W), .IGNORE_MASK(CR_MASK)) u_cmpHiA (
    .rxByte(byteData), .refByte(hiAddrA), .hit(hiAHit)
  );

  addr_compare #(.WIDTH(ADDR_W), .IGNORE_MASK('0)) u_cmpHiB (
    .rxByte(byteData), .refByte(hiAddrB), .hit(hiBHit)
  );

  for (genvar g = 0; g < N_BCAST; g++) begin : g_bcast
    localparam logic [ADDR_W-1:0] BC_VAL = (g == 0) ? BCAST_A : BCAST_B;
    addr_compare #(.WIDTH(ADDR_W), .IGNORE_MASK(CR_MASK)) u_cmpBc (
      .rxByte(byteData), .refByte(BC_VAL), .hit(bcastHit[g])
    );
  end

  assign loRef[0] = loAddrA;
  assign loRef[1] = loAddrB;

  for (genvar g = 0; g < N_LO_REG; g++) begin : g_low
    addr_compare #(.WIDTH(ADDR_W), .IGNORE_MASK('0)) u_cmpLo (
      .rxByte(byteData), .refByte(loRef[g]), .hit(loHit[g])
    );
  end

  always_comb begin
    hiHitNow = 1'b1;
    if (hiAHit) begin
      hiCodeNow = {1'b1, byteData[CR_BIT]};
    end else if (hiBHit) begin
      hiCodeNow = HI_CODE_REG_B;
    end else if (|bcastHit) begin
      hiCodeNow = HI_CODE_BCAST;
    end else begin
      hiCodeNow = HI_CODE_NONE;
      hiHitNow  = 1'b0;
    end
    loCodeNow = loHit[0];
    loHitNow  = |loHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiPendCode  <= '0;
      hiPendHit   <= 1'b0;
      frameAccept <= 1'b0;
      hiCode      <= '0;
      loCode      <= 1'b0;
    end else begin
      if (strobes.startFrame) begin
        frameAccept <= 1'b0;
        hiCode      <= '0;
        loCode      <= 1'b0;
      end
      if (strobes.takeHi) begin
        hiPendCode <= hiCodeNow;
        hiPendHit  <= hiHitNow;
      end
      if (strobes.takeLo) begin
        loCode      <= loCodeNow;
        hiCode      <= strobes.twoMode ? hiPendCode : HI_CODE_NONE;
        frameAccept <= strobes.twoMode ? (hiPendHit && loHitNow) : loHitNow;
      end
    end
  end

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.startFrame && !strobes.takeLo) |=> $stable({frameAccept, hiCode, loCode})); // R9

  AST_HI_MISS_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeLo && strobes.twoMode && !hiPendHit) |=> !frameAccept); // R8

  AST_LO_MISS_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeLo && !loHitNow) |=> !frameAccept && !loCode); // R6

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_addr_filter_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CR_BIT = 1,
  parameter logic [ADDR_W-1:0] BCAST_A = 8'hFE,
  parameter logic [ADDR_W-1:0] BCAST_B = 8'hFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic              sofStb,
  input  logic [ADDR_W-1:0] byteData,
  input  logic              twoByteMode,
  input  logic [ADDR_W-1:0] hiAddrA,
  input  logic [ADDR_W-1:0] hiAddrB,
  input  logic [ADDR_W-1:0] loAddrA,
  input  logic [ADDR_W-1:0] loAddrB,
  output logic              frameAccept,
  output logic [1:0]        hiCode,
  output logic              loCode
);

  ctrlStrobes_t strobes;

  addr_filter_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .sofStb(sofStb),
    .twoByteMode(twoByteMode), .strobes(strobes)
  );

  addr_filter_dp #(
    .ADDR_W(ADDR_W), .CR_BIT(CR_BIT), .BCAST_A(BCAST_A), .BCAST_B(BCAST_B)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteData(byteData),
    .hiAddrA(hiAddrA), .hiAddrB(hiAddrB), .loAddrA(loAddrA), .loAddrB(loAddrB),
    .frameAccept(frameAccept), .hiCode(hiCode), .loCode(loCode)
  );

  AST_ONEBYTE_HI_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && sofStb && !twoByteMode) |=> (hiCode == 2'b00)); // R7

  AST_SOF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && sofStb && twoByteMode) |=> !frameAccept && hiCode == 2'b00 && !loCode); // R10

endmodule

// File: tb/hdlc_addr_filter_test.sv
`timescale 1ns/1ps
module hdlc_addr_filter_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       byteValid;
  logic       sofStb;
  logic [7:0] byteData;
  logic       twoByteMode;
  logic [7:0] hiAddrA, hiAddrB, loAddrA, loAddrB;
  logic       frameAccept;
  logic [1:0] hiCode;
  logic       loCode;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  hdlc_addr_filter uut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .sofStb(sofStb),
    .byteData(byteData), .twoByteMode(twoByteMode),
    .hiAddrA(hiAddrA), .hiAddrB(hiAddrB), .loAddrA(loAddrA), .loAddrB(loAddrB),
    .frameAccept(frameAccept), .hiCode(hiCode), .loCode(loCode)
  );

  function automatic logic [3:0] outVec();
    return {frameAccept, hiCode, loCode};
  endfunction

  // Expected {accept, hiCode, loCode} built from the requirements
  function automatic logic [3:0] model(input logic two, input logic [7:0] h, input logic [7:0] l);
    logic [1:0] hc;
    logic hh, lc, lh;
    lc = (l == loAddrA);
    lh = (l == loAddrA) || (l == loAddrB);
    if (!two) return {lh, 2'b00, lc};
    if ((h | 8'h02) == (hiAddrA | 8'h02)) begin hc = {1'b1, h[1]}; hh = 1'b1; end
    else if (h == hiAddrB)               begin hc = 2'b00; hh = 1'b1; end
    else if ((h | 8'h02) == 8'hFE)       begin hc = 2'b01; hh = 1'b1; end
    else                                 begin hc = 2'b00; hh = 1'b0; end
    return {hh && lh, hc, lc};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: {accept,hi,lo} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pushByte(input logic sof, input logic [7:0] d);
    @(negedge clk);
    byteValid = 1'b1;
    sofStb    = sof;
    byteData  = d;
    @(negedge clk);
    byteValid = 1'b0;
    sofStb    = 1'b0;
  endtask

  task automatic frame2(input string req, input logic [7:0] h, input logic [7:0] l);
    twoByteMode = 1'b1;
    pushByte(1'b1, h);
    pushByte(1'b0, l);
    check(req, outVec(), model(1'b1, h, l));
  endtask

  task automatic frame1(input string req, input logic [7:0] l);
    twoByteMode = 1'b0;
    pushByte(1'b1, l);
    check(req, outVec(), model(1'b0, 8'h00, l));
  endtask

  task automatic setRegs(input logic [7:0] ha, input logic [7:0] hb, input logic [7:0] la, input logic [7:0] lb);
    hiAddrA = ha; hiAddrB = hb; loAddrA = la; loAddrB = lb;
  endtask

  task automatic testReset();
    check("R1 reset", outVec(), 4'b0000);
  endtask

  task automatic testRegA();
    setRegs(8'h40, 8'h22, 8'h11, 8'h33);
    frame2("R2 hiA C/R=1", 8'h42, 8'h11);
    check("R2 hiA code 11 literal", outVec(), 4'b1111);
    frame2("R2 hiA C/R=0", 8'h40, 8'h33);
    check("R2 hiA code 10 literal", outVec(), 4'b1100);
  endtask

  task automatic testRegB();
    setRegs(8'h40, 8'h22, 8'h11, 8'h33);
    frame2("R3 hiB exact", 8'h22, 8'h11);
    check("R3 hiB code 00 literal", outVec(), 4'b1001);
    frame2("R3 hiB C/R flipped misses", 8'h20, 8'h11);
    check("R3 R8 hi miss rejects", outVec(), 4'b0001);
  endtask

  task automatic testBcast();
    setRegs(8'h40, 8'h22, 8'h11, 8'h33);
    frame2("R4 bcast FE", 8'hFE, 8'h33);
    check("R4 bcast FE literal", outVec(), 4'b1010);
    frame2("R4 bcast FC", 8'hFC, 8'h11);
    setRegs(8'h40, 8'hFC, 8'h11, 8'h33);
    frame2("R4 hiB over bcast", 8'hFC, 8'h11);
    check("R4 hiB over bcast literal", outVec(), 4'b1001);
  endtask

  task automatic testSameHi();
    setRegs(8'h22, 8'h22, 8'h11, 8'h33);
    frame2("R5 equal regs C/R=1", 8'h22, 8'h11);
    check("R5 equal regs literal", outVec(), 4'b1111);
    frame2("R5 equal regs C/R=0", 8'h20, 8'h33);
  endtask

  task automatic testLow();
    setRegs(8'h40, 8'h22, 8'h55, 8'h55);
    frame2("R6 equal low regs pick A", 8'h40, 8'h55);
    check("R6 low A priority literal", outVec(), 4'b1101);
    setRegs(8'h40, 8'h22, 8'h11, 8'h33);
    frame2("R8 low miss rejects", 8'h40, 8'h99);
    check("R8 low miss literal", outVec(), 4'b0100);
  endtask

  task automatic testOneByte();
    setRegs(8'h40, 8'h22, 8'h11, 8'h33);
    frame1("R7 one-byte loA", 8'h11);
    check("R7 one-byte loA literal", outVec(), 4'b1001);
    frame1("R7 one-byte loB", 8'h33);
    frame1("R7 R8 one-byte miss", 8'h40);
    check("R8 one-byte miss literal", outVec(), 4'b0000);
  endtask

  task automatic testHoldRestart();
    setRegs(8'h40, 8'h22, 8'h11, 8'h33);
    frame2("R9 base frame", 8'h42, 8'h11);
    pushByte(1'b0, 8'h99);
    pushByte(1'b0, 8'h33);
    check("R9 trailing bytes ignored", outVec(), 4'b1111);
    repeat (3) @(negedge clk);
    check("R9 idle hold", outVec(), 4'b1111);
    twoByteMode = 1'b1;
    pushByte(1'b1, 8'h22);
    check("R10 sof clears", outVec(), 4'b0000);
    pushByte(1'b1, 8'hFE);
    check("R10 restart still clear", outVec(), 4'b0000);
    pushByte(1'b0, 8'h33);
    check("R10 restart result", outVec(), 4'b1010);
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    byteValid = 1'b0;
    sofStb = 1'b0;
    byteData = 8'h00;
    twoByteMode = 1'b1;
    setRegs(8'h40, 8'h22, 8'h11, 8'h33);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegA();
    testRegB();
    testBcast();
    testSameHi();
    testLow();
    testOneByte();
    testHoldRestart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule